// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Prioritizer

This block gathers 96 peripheral interrupt requests, organised as 12 groups of 8 sources, and offers the most urgent one to a CPU. Each source keeps a pending flag that a single-cycle request pulse sets. A request counts only when it passes three gates: the peripheral enable, the per-source enable held for its group, and the CPU-side gate. The CPU-side gate needs the per-line enable set and the global mask clear. Group g drives CPU line g. Each CPU line has a flag that latches the group's request.

The CPU takes the interrupt by pulsing an acknowledge. On that edge the block does four things: it clears the winning source's pending flag, clears the line's CPU flag, sets the group's acknowledge bit and sets the global mask. One cycle later it reports the group and source numbers. A group with its acknowledge bit set stays silent until software clears that bit. Software can also drop a pending source before it is taken.

Top module: `irqp_top`

## Requirements
- R1: After reset, all pending flags, source enables, line enables, CPU flags and group acknowledge bits are 0, `gmask_o` is 1, and `irq_o` and `taken_o` are 0. A request pulse arriving right after reset does not raise a CPU flag.
- R2: Source s (1..8) of group g (1..12) sits at bit (g-1)*8+(s-1) of every 96-bit vector. A pulse on `req_i` sets that source's pending flag only when the same bit of `periph_en_i` is 1. A pulse with the bit at 0 is lost.
- R3: A pending source whose source enable is 0 stays pending. Once it is enabled, its group raises a request.
- R4: A group requests when it has an enabled pending source and its acknowledge bit is clear. The request sets `cpu_flag_o[g-1]` at the next clock edge. The flag then holds until that line is taken.
- R5: `irq_o` is 1 only when some CPU flag is set, that line's enable bit is 1 and `gmask_o` is 0.
- R6: Among the eligible lines, the lowest-numbered one wins. `irq_line_o` gives its number, 1..12, or 0 when `irq_o` is 0.
- R7: Within a group, the enabled pending source with the lowest number wins. The same source is never reported twice for one pulse.
- R8: `ack_i` high while `irq_o` is 1 takes the winning line at that clock edge. At that edge the winning source's pending flag clears, the line's CPU flag clears, the group's acknowledge bit sets and `gmask_o` sets. On the following cycle `taken_o` is 1 and `vec_grp_o`/`vec_src_o` carry the 1-based group and source numbers.
- R9: While a group's acknowledge bit is set, that group raises no new CPU flag. A pulse on `grp_ack_clr_i[g-1]` clears the bit.
- R10: A pulse on `pend_clr_i` clears a pending flag. A source cleared before it ever raised a CPU flag produces no interrupt.
- R11: `ack_i` while `irq_o` is 0 has no effect: `taken_o` stays 0 and `gmask_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 96 | Request pulses, one per source |
| periph_en_i | input | 96 | Peripheral-level enables |
| pend_clr_i | input | 96 | Software pending clear pulses |
| src_en_we_i | input | 1 | Load strobe for source enables |
| src_en_wd_i | input | 96 | Source enable data |
| line_en_we_i | input | 1 | Load strobe for CPU line enables |
| line_en_wd_i | input | 12 | CPU line enable data |
| grp_ack_clr_i | input | 12 | Group acknowledge clear pulses |
| gmask_clr_i | input | 1 | Clears the global mask |
| ack_i | input | 1 | CPU fetch/acknowledge |
| irq_o | output | 1 | Interrupt offered to the CPU |
| irq_line_o | output | 4 | Winning line number (1..12, 0 = none) |
| cpu_flag_o | output | 12 | CPU-side line flags |
| gmask_o | output | 1 | Global mask state |
| grp_ack_o | output | 12 | Group acknowledge bits |
| taken_o | output | 1 | Vector valid, one cycle after a take |
| vec_grp_o | output | 4 | Taken group number |
| vec_src_o | output | 4 | Taken source number (0 if none was left) |

## Verification
A request pulse sampled at one edge sets the pending flag there. The group request that follows is combinational, so the CPU flag and `irq_o` appear after the second edge. An acknowledge sampled at edge k updates the flags, the masks and the group acknowledge bit at k. The vector outputs appear after edge k, for exactly one cycle. The bench drives every input one time unit after a rising edge and checks outputs one unit after the edge it counts for each result. Negative checks, such as a lost pulse or a cleared source, wait past the cycle in which the CPU flag would have appeared.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int unsigned NUM_GRP     = 12;
  localparam int unsigned SRC_PER_GRP = 8;
  localparam int unsigned NUM_SRC     = NUM_GRP * SRC_PER_GRP;
endpackage

// File: rtl/irqp_grp_slot.sv
module irqp_grp_slot #(
  parameter int unsigned NS  = 8,
  parameter int unsigned SIW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NS-1:0]  set_i,
  input  logic [NS-1:0]  clr_i,
  input  logic           en_we_i,
  input  logic [NS-1:0]  en_wd_i,
  input  logic           take_i,
  input  logic           ack_clr_i,
  output logic           req_o,
  output logic [SIW-1:0] sel_o,
  output logic           sel_vld_o,
  output logic           ack_o
);
  logic [NS-1:0] pend_q, en_q, act, take_mask;
  logic          ack_q;

  assign act = pend_q & en_q;

  // lowest index wins
  always_comb begin
    sel_o     = '0;
    sel_vld_o = 1'b0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (act[i]) begin
        sel_o     = SIW'(i);
        sel_vld_o = 1'b1;
      end
    end
  end

  assign take_mask = (take_i && sel_vld_o) ? (NS'(1) << sel_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_i & ~take_mask) | set_i;
      if (en_we_i) en_q <= en_wd_i;
      if (take_i)         ack_q <= 1'b1;
      else if (ack_clr_i) ack_q <= 1'b0;
    end
  end

  assign req_o = (|act) & ~ack_q;
  assign ack_o = ack_q;
endmodule

// File: rtl/irqp_line_arb.sv
module irqp_line_arb #(
  parameter int unsigned NG  = 12,
  parameter int unsigned LIW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic [NG-1:0]  flag_i,
  input  logic [NG-1:0]  en_i,
  input  logic           mask_i,
  output logic           irq_o,
  output logic [LIW-1:0] idx_o
);
  logic [NG-1:0] elig;

  assign elig = mask_i ? '0 : (flag_i & en_i);

  always_comb begin
    idx_o = '0;
    irq_o = 1'b0;
    for (int i = NG - 1; i >= 0; i--) begin
      if (elig[i]) begin
        idx_o = LIW'(i);
        irq_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqp_top.sv
module irqp_top
  import irqp_pkg::*;
#(
  parameter int unsigned NG  = NUM_GRP,
  parameter int unsigned NS  = SRC_PER_GRP,
  parameter int unsigned GNW = $clog2(NG + 1),
  parameter int unsigned SNW = $clog2(NS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NG*NS-1:0] req_i,
  input  logic [NG*NS-1:0] periph_en_i,
  input  logic [NG*NS-1:0] pend_clr_i,
  input  logic             src_en_we_i,
  input  logic [NG*NS-1:0] src_en_wd_i,
  input  logic             line_en_we_i,
  input  logic [NG-1:0]    line_en_wd_i,
  input  logic [NG-1:0]    grp_ack_clr_i,
  input  logic             gmask_clr_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [GNW-1:0]   irq_line_o,
  output logic [NG-1:0]    cpu_flag_o,
  output logic             gmask_o,
  output logic [NG-1:0]    grp_ack_o,
  output logic             taken_o,
  output logic [GNW-1:0]   vec_grp_o,
  output logic [SNW-1:0]   vec_src_o
);
  localparam int unsigned GIW = (NG > 1) ? $clog2(NG) : 1;
  localparam int unsigned SIW = (NS > 1) ? $clog2(NS) : 1;

  logic [NG-1:0]  grp_req, sel_vld, take_oh, flag_q, line_en_q;
  logic [SIW-1:0] sel_w [NG];
  logic [GIW-1:0] line_idx;
  logic           irq, take, gmask_q;
  logic           taken_q;
  logic [GNW-1:0] vec_grp_q;
  logic [SNW-1:0] vec_src_q;

  assign take    = ack_i & irq;
  assign take_oh = take ? (NG'(1) << line_idx) : '0;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    irqp_grp_slot #(.NS(NS), .SIW(SIW)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (req_i[g*NS +: NS] & periph_en_i[g*NS +: NS]),
      .clr_i     (pend_clr_i[g*NS +: NS]),
      .en_we_i   (src_en_we_i),
      .en_wd_i   (src_en_wd_i[g*NS +: NS]),
      .take_i    (take_oh[g]),
      .ack_clr_i (grp_ack_clr_i[g]),
      .req_o     (grp_req[g]),
      .sel_o     (sel_w[g]),
      .sel_vld_o (sel_vld[g]),
      .ack_o     (grp_ack_o[g])
    );
  end

  irqp_line_arb #(.NG(NG), .LIW(GIW)) u_arb (
    .flag_i (flag_q),
    .en_i   (line_en_q),
    .mask_i (gmask_q),
    .irq_o  (irq),
    .idx_o  (line_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= '0;
      line_en_q <= '0;
      gmask_q   <= 1'b1;
      taken_q   <= 1'b0;
      vec_grp_q <= '0;
      vec_src_q <= '0;
    end else begin
      flag_q <= (flag_q | grp_req) & ~take_oh;
      if (line_en_we_i) line_en_q <= line_en_wd_i;
      if (take)             gmask_q <= 1'b1;
      else if (gmask_clr_i) gmask_q <= 1'b0;
      taken_q <= take;
      if (take) begin
        vec_grp_q <= GNW'(line_idx) + GNW'(1);
        vec_src_q <= sel_vld[line_idx] ? (SNW'(sel_w[line_idx]) + SNW'(1)) : '0;
      end
    end
  end

  assign irq_o      = irq;
  assign irq_line_o = irq ? (GNW'(line_idx) + GNW'(1)) : '0;
  assign cpu_flag_o = flag_q;
  assign gmask_o    = gmask_q;
  assign taken_o    = taken_q;
  assign vec_grp_o  = vec_grp_q;
  assign vec_src_o  = vec_src_q;
endmodule

// File: rtl/irqp_chk.sv
module irqp_chk #(
  parameter int unsigned NG  = 12,
  parameter int unsigned NS  = 8,
  parameter int unsigned GNW = 4,
  parameter int unsigned SNW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ack_i,
  input logic           irq_o,
  input logic [GNW-1:0] irq_line_o,
  input logic [NG-1:0]  cpu_flag_o,
  input logic           gmask_o,
  input logic [NG-1:0]  grp_ack_o,
  input logic           taken_o,
  input logic [GNW-1:0] vec_grp_o,
  input logic [SNW-1:0] vec_src_o
);
  p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!gmask_o && irq_line_o != '0 && cpu_flag_o[irq_line_o - GNW'(1)]));

  p_no_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> irq_line_o == '0);

  p_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (taken_o && gmask_o && vec_grp_o == $past(irq_line_o)));

  p_flag_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> !cpu_flag_o[vec_grp_o - GNW'(1)]);

  p_grp_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> grp_ack_o[vec_grp_o - GNW'(1)]);

  p_src_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> vec_src_o <= SNW'(NS));

  p_ack_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (!taken_o && gmask_o == $past(gmask_o)));
endmodule

bind irqp_top irqp_chk #(.NG(NG), .NS(NS), .GNW(GNW), .SNW(SNW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .irq_line_o (irq_line_o),
  .cpu_flag_o (cpu_flag_o),
  .gmask_o    (gmask_o),
  .grp_ack_o  (grp_ack_o),
  .taken_o    (taken_o),
  .vec_grp_o  (vec_grp_o),
  .vec_src_o  (vec_src_o)
);

// File: tb/irqp_top_tb_top.sv
module irqp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 12;
  localparam int NS = 8;
  localparam int NT = NG * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] req = '0, periph_en = '1, pend_clr = '0, src_en_wd = '0;
  logic          src_en_we = 1'b0, line_en_we = 1'b0, gmask_clr = 1'b0, ack = 1'b0;
  logic [NG-1:0] line_en_wd = '0, grp_ack_clr = '0;
  logic          irq, gmask, taken;
  logic [3:0]    irq_line, vec_grp, vec_src;
  logic [NG-1:0] cpu_flag, grp_ack;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irqp_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .periph_en_i(periph_en),
    .pend_clr_i(pend_clr), .src_en_we_i(src_en_we), .src_en_wd_i(src_en_wd),
    .line_en_we_i(line_en_we), .line_en_wd_i(line_en_wd), .grp_ack_clr_i(grp_ack_clr),
    .gmask_clr_i(gmask_clr), .ack_i(ack), .irq_o(irq), .irq_line_o(irq_line),
    .cpu_flag_o(cpu_flag), .gmask_o(gmask), .grp_ack_o(grp_ack), .taken_o(taken),
    .vec_grp_o(vec_grp), .vec_src_o(vec_src)
  );

  function automatic int idx(int g, int s);
    return (g - 1) * NS + (s - 1);
  endfunction

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_req(int g, int s);
    req[idx(g, s)] = 1'b1;
    step();
    req = '0;
  endtask

  task automatic write_src_en(logic [NT-1:0] v);
    src_en_wd = v; src_en_we = 1'b1;
    step();
    src_en_we = 1'b0;
  endtask

  task automatic unmask();
    gmask_clr = 1'b1;
    step();
    gmask_clr = 1'b0;
  endtask

  task automatic take();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic release_grp(int g);
    grp_ack_clr[g-1] = 1'b1;
    step();
    grp_ack_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags", int'(cpu_flag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 gmask", int'(gmask), 1);
    chk("R1 grp_ack", int'(grp_ack), 0);
    chk("R1 taken", int'(taken), 0);
    pulse_req(1, 1);
    step();
    chk("R1 src enables cleared", int'(cpu_flag), 0);
    pend_clr[idx(1, 1)] = 1'b1;
    step();
    pend_clr = '0;
  endtask

  task automatic t_basic();
    unmask();
    pulse_req(4, 3);
    chk("R4 flag not yet", int'(cpu_flag), 0);
    step();
    chk("R4 flag line 4", int'(cpu_flag), 1 << 3);
    chk("R5 irq", int'(irq), 1);
    chk("R6 line", int'(irq_line), 4);
    take();
    chk("R8 taken", int'(taken), 1);
    chk("R8 grp", int'(vec_grp), 4);
    chk("R8 src", int'(vec_src), 3);
    chk("R8 gmask set", int'(gmask), 1);
    chk("R8 grp_ack", int'(grp_ack), 1 << 3);
    chk("R8 flag cleared", int'(cpu_flag), 0);
    step();
    chk("R8 taken one cycle", int'(taken), 0);
    release_grp(4);
    step();
    chk("R8 pending cleared", int'(cpu_flag), 0);
  endtask

  task automatic t_periph_gate();
    periph_en[idx(2, 2)] = 1'b0;
    pulse_req(2, 2);
    step();
    chk("R2 gated pulse lost", int'(cpu_flag), 0);
    periph_en = '1;
    step(); step();
    chk("R2 no late pending", int'(cpu_flag), 0);
  endtask

  task automatic t_disabled_pending();
    logic [NT-1:0] en = '1;
    en[idx(6, 1)] = 1'b0;
    write_src_en(en);
    pulse_req(6, 1);
    step();
    chk("R3 disabled no flag", int'(cpu_flag), 0);
    write_src_en('1);
    step();
    chk("R3 flag after enable", int'(cpu_flag), 1 << 5);
    unmask();
    take();
    chk("R3 grp", int'(vec_grp), 6);
    chk("R3 src", int'(vec_src), 1);
    release_grp(6);
  endtask

  task automatic t_line_prio();
    req[idx(5, 1)] = 1'b1;
    req[idx(2, 8)] = 1'b1;
    step();
    req = '0;
    step();
    unmask();
    chk("R6 lower line wins", int'(irq_line), 2);
    take();
    chk("R6 grp", int'(vec_grp), 2);
    chk("R7 src", int'(vec_src), 8);
    chk("R5 masked after take", int'(irq), 0);
    chk("R4 other flag held", int'(cpu_flag), 1 << 4);
    unmask();
    chk("R6 next line", int'(irq_line), 5);
    take();
    chk("R6 second grp", int'(vec_grp), 5);
    grp_ack_clr = 12'h012;
    step();
    grp_ack_clr = '0;
  endtask

  task automatic t_line_en();
    line_en_wd = ~(12'h1 << 6); line_en_we = 1'b1;
    step();
    line_en_we = 1'b0;
    unmask();
    pulse_req(7, 2);
    step();
    chk("R5 flag set", int'(cpu_flag), 1 << 6);
    chk("R5 line disabled no irq", int'(irq), 0);
    line_en_wd = '1; line_en_we = 1'b1;
    step();
    line_en_we = 1'b0;
    chk("R5 line enabled irq", int'(irq), 1);
    take();
    chk("R5 grp", int'(vec_grp), 7);
    chk("R5 src", int'(vec_src), 2);
    release_grp(7);
  endtask

  task automatic t_src_prio();
    req[idx(3, 5)] = 1'b1;
    req[idx(3, 2)] = 1'b1;
    step();
    req = '0;
    step();
    unmask();
    take();
    chk("R7 first src", int'(vec_src), 2);
    step(); step();
    chk("R9 group blocked", int'(cpu_flag), 0);
    release_grp(3);
    chk("R9 ack bit cleared", int'(grp_ack), 0);
    step();
    chk("R9 group resumes", int'(cpu_flag), 1 << 2);
    unmask();
    take();
    chk("R7 second src", int'(vec_src), 5);
    release_grp(3);
    step();
    chk("R7 no repeat", int'(cpu_flag), 0);
  endtask

  task automatic t_sw_clear();
    logic [NT-1:0] en = '1;
    en[idx(9, 4)] = 1'b0;
    write_src_en(en);
    pulse_req(9, 4);
    pend_clr[idx(9, 4)] = 1'b1;
    step();
    pend_clr = '0;
    write_src_en('1);
    step(); step();
    chk("R10 cleared flag", int'(cpu_flag), 0);
    chk("R10 cleared irq", int'(irq), 0);
  endtask

  task automatic t_ack_idle();
    unmask();
    chk("R11 unmasked", int'(gmask), 0);
    take();
    chk("R11 no taken", int'(taken), 0);
    chk("R11 gmask kept", int'(gmask), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    step();
    t_reset();
    write_src_en('1);
    line_en_wd = '1; line_en_we = 1'b1;
    step();
    line_en_we = 1'b0;
    t_basic();
    t_periph_gate();
    t_disabled_pending();
    t_line_prio();
    t_line_en();
    t_src_prio();
    t_sw_clear();
    t_ack_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule